// File: doc/BRIEF.md
# Double-Precision Float to 64-bit Integer Converter

This block turns a 64-bit IEEE-754 double into a 64-bit two's-complement integer in one registered stage. Each request carries the operand, a two-bit rounding mode and a flag-reporting enable. One clock later the block presents the integer together with invalid, overflow and inexact indications and a valid strobe.

Values too large for the integer range are not clamped. The block returns the low 64 bits of the exact rounded value. A caller that wants an unsigned conversion can therefore use the same operation and read the 64 bits as unsigned. With reporting switched off, overflow and inexact stay quiet. Invalid for a NaN is always raised.

Top module: `dtoi_conv`

## Requirements
- R1: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` is high. Reset clears `out_valid`, the result and all three flags to 0.
- R2: A finite input whose value is an integer below 2^63 in magnitude converts exactly, with no flag raised. Plus zero and minus zero both give 0 and no flag.
- R3: When the unbiased exponent minus 52 is between 0 and 62, the result is the low 64 bits of the value. Overflow is raised when reporting is on and significant bits fall off the top; this happens once the exponent minus 1075 is 12 or more. When the exponent minus 1075 is 63 or more, the result is 0 and no flag is raised.
- R4: Mode 00 rounds to nearest. A discarded part above one half adds 1. A part of exactly one half adds 1 only when the kept LSB is 1.
- R5: Mode 01 rounds toward zero and drops the discarded part.
- R6: Mode 10 rounds toward minus infinity. It adds 1 to the magnitude of a negative input that has a non-zero discarded part.
- R7: Mode 11 rounds toward plus infinity. It adds 1 to the magnitude of a positive input that has a non-zero discarded part.
- R8: A non-zero discarded part raises inexact when reporting is on. A value right-shifted by 63 or more places keeps magnitude 0 and behaves as a non-zero part below one half.
- R9: A denormal input (exponent field 0, fraction non-zero) behaves as magnitude 0 with a non-zero part below one half.
- R10: Exponent field all ones gives result 0. A non-zero fraction (NaN) raises invalid whatever the reporting enable. A zero fraction (infinity) raises overflow only when reporting is on.
- R11: With `in_report` low, overflow and inexact stay 0 and the result is unchanged.
- R12: A negative input yields the two's-complement negation of its rounded magnitude.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_data | input | 64 | Double operand: bit 63 sign, bits 62:52 exponent, bits 51:0 fraction |
| in_mode | input | 2 | Rounding mode: 00 nearest-even, 01 toward zero, 10 toward minus infinity, 11 toward plus infinity |
| in_report | input | 1 | Enables overflow and inexact flags |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_result | output | 64 | Converted integer, low 64 bits |
| out_invalid | output | 1 | NaN operand |
| out_overflow | output | 1 | Infinity, or bits lost above bit 63 |
| out_inexact | output | 1 | Non-zero discarded fraction |

## Verification
The conversion has a single stage, so any wrong internal decision shows at the ports in the cycle after the strobe. A misclassified operand shows as a wrong flag combination, and at most one of the three flags can ever be set. A wrong shift amount or remainder alignment shows as an off-by-one or a grossly wrong integer. Rounding errors only show near half-way values and for negative operands. The directed vectors therefore sit on those edges, and an independently written reference model checks a randomized spread of exponents around the integer range.

// File: rtl/dtoi_pkg.sv
package dtoi_pkg;

  parameter int EXP_W  = 11;
  parameter int FRAC_W = 52;
  parameter int INT_W  = 64;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_ZERO    = 2'b01,
    RM_DOWN    = 2'b10,
    RM_UP      = 2'b11
  } rmode_e;

  // Decide whether the truncated magnitude is bumped by one.
  function automatic logic bump_decision(rmode_e    mode,
                                         logic      neg,
                                         logic      keep_lsb,
                                         logic      above_half,
                                         logic      at_half,
                                         logic      nonzero);
    logic b;
    case (mode)
      RM_NEAREST: b = above_half | (at_half & keep_lsb);
      RM_ZERO:    b = 1'b0;
      RM_DOWN:    b = neg & nonzero;
      default:    b = ~neg & nonzero;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/dtoi_align.sv
module dtoi_align #(
  parameter int EXP_W  = dtoi_pkg::EXP_W,
  parameter int FRAC_W = dtoi_pkg::FRAC_W,
  parameter int INT_W  = dtoi_pkg::INT_W
) (
  input  logic [EXP_W+FRAC_W:0] op,
  input  logic                  report,
  output logic                  neg,
  output logic [INT_W-1:0]      mag,
  output logic [INT_W-1:0]      rem,
  output logic                  raw_invalid,
  output logic                  raw_overflow
);
  localparam int MANT_W   = FRAC_W + 1;
  localparam int BIAS     = (1 << (EXP_W - 1)) - 1;
  localparam int ZERO_SH  = BIAS + FRAC_W;
  localparam int FAR_SH   = INT_W - 1;
  localparam int SH_W     = $clog2(INT_W);
  localparam int WIDE_W   = INT_W + MANT_W;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic [MANT_W-1:0] mant;

  assign neg    = op[EXP_W+FRAC_W];
  assign exp_f  = op[EXP_W+FRAC_W-1:FRAC_W];
  assign frac_f = op[FRAC_W-1:0];
  assign mant   = {1'b1, frac_f};

  // Classification events, named for visibility.
  logic is_special, is_nan, is_inf, is_zero, is_denorm, is_normal;
  assign is_special = &exp_f;
  assign is_nan     = is_special & (|frac_f);
  assign is_inf     = is_special & ~(|frac_f);
  assign is_zero    = ~(|exp_f) & ~(|frac_f);
  assign is_denorm  = ~(|exp_f) & (|frac_f);
  assign is_normal  = ~is_special & (|exp_f);

  // Signed distance of the binary point from the fraction LSB.
  logic signed [31:0] sh, nsh;
  assign sh  = $signed({{(32-EXP_W){1'b0}}, exp_f}) - ZERO_SH;
  assign nsh = -sh;

  logic go_left, left_far, right_far;
  assign go_left   = ~sh[31];
  assign left_far  = go_left & (sh >= FAR_SH);
  assign right_far = ~go_left & (nsh >= FAR_SH);

  logic [SH_W-1:0] lamt, ramt;
  assign lamt = left_far  ? '0 : sh[SH_W-1:0];
  assign ramt = right_far ? '0 : nsh[SH_W-1:0];

  logic [WIDE_W-1:0] lwide, rwide;
  assign lwide = {{INT_W{1'b0}}, mant} << lamt;
  assign rwide = {mant, {INT_W{1'b0}}} >> ramt;

  logic left_lost;
  assign left_lost = |lwide[WIDE_W-1:INT_W];

  always_comb begin
    mag          = '0;
    rem          = '0;
    raw_invalid  = 1'b0;
    raw_overflow = 1'b0;
    if (is_special) begin
      raw_invalid  = is_nan;
      raw_overflow = is_inf & report;
    end else if (is_denorm) begin
      rem = {{(INT_W-1){1'b0}}, 1'b1};
    end else if (is_normal) begin
      if (go_left) begin
        if (!left_far) begin
          mag          = lwide[INT_W-1:0];
          raw_overflow = report & left_lost;
        end
      end else if (right_far) begin
        rem = {{(INT_W-1){1'b0}}, 1'b1};
      end else begin
        mag = {{(INT_W-MANT_W){1'b0}}, rwide[WIDE_W-1:INT_W]};
        rem = rwide[INT_W-1:0];
      end
    end
  end

  logic unused_zero;
  assign unused_zero = is_zero;

endmodule

// File: rtl/dtoi_round.sv
module dtoi_round #(
  parameter int INT_W = dtoi_pkg::INT_W
) (
  input  dtoi_pkg::rmode_e  mode,
  input  logic              report,
  input  logic              neg,
  input  logic [INT_W-1:0]  mag,
  input  logic [INT_W-1:0]  rem,
  output logic [INT_W-1:0]  value,
  output logic              inexact
);
  localparam logic [INT_W-1:0] HALF = {1'b1, {(INT_W-1){1'b0}}};

  logic above_half, at_half, rem_nz, bump;
  logic [INT_W-1:0] rounded;

  assign above_half = rem > HALF;
  assign at_half    = rem == HALF;
  assign rem_nz     = |rem;
  assign bump       = dtoi_pkg::bump_decision(mode, neg, mag[0], above_half, at_half, rem_nz);
  assign rounded    = mag + {{(INT_W-1){1'b0}}, bump};
  assign value      = neg ? (~rounded + 1'b1) : rounded;
  assign inexact    = report & rem_nz;

endmodule

// File: rtl/dtoi_conv.sv
module dtoi_conv #(
  parameter int EXP_W  = dtoi_pkg::EXP_W,
  parameter int FRAC_W = dtoi_pkg::FRAC_W,
  parameter int INT_W  = dtoi_pkg::INT_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [EXP_W+FRAC_W:0]   in_data,
  input  logic [1:0]              in_mode,
  input  logic                    in_report,
  output logic                    out_valid,
  output logic [INT_W-1:0]        out_result,
  output logic                    out_invalid,
  output logic                    out_overflow,
  output logic                    out_inexact
);
  localparam int TOP   = EXP_W + FRAC_W;
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;

  logic              a_neg, raw_inv, raw_ovf, rnd_inx;
  logic [INT_W-1:0]  a_mag, a_rem, rnd_val;

  dtoi_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) u_align (
    .op           (in_data),
    .report       (in_report),
    .neg          (a_neg),
    .mag          (a_mag),
    .rem          (a_rem),
    .raw_invalid  (raw_inv),
    .raw_overflow (raw_ovf)
  );

  dtoi_round #(.INT_W(INT_W)) u_round (
    .mode    (dtoi_pkg::rmode_e'(in_mode)),
    .report  (in_report),
    .neg     (a_neg),
    .mag     (a_mag),
    .rem     (a_rem),
    .value   (rnd_val),
    .inexact (rnd_inx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_result   <= '0;
      out_invalid  <= 1'b0;
      out_overflow <= 1'b0;
      out_inexact  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result   <= rnd_val;
        out_invalid  <= raw_inv;
        out_overflow <= raw_ovf;
        out_inexact  <= rnd_inx;
      end
    end
  end

  // R1: strobe timing
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R2: signed zeros give zero and no flag
  a_r2_zero_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_data[TOP-1:0] == '0) |=>
      (out_result == '0 && !out_invalid && !out_overflow && !out_inexact));

  // R10: NaN gives zero and invalid
  a_r10_nan_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (&in_data[TOP-1:FRAC_W]) && (|in_data[FRAC_W-1:0])) |=>
      (out_invalid && out_result == '0));

  // R11: reporting disabled keeps overflow and inexact quiet
  a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_report) |=> (!out_overflow && !out_inexact));

  // R5: truncation of a magnitude below one yields zero
  a_r5_trunc_small: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == 2'b01 && in_data[TOP-1:FRAC_W] < BIAS) |=>
      (out_result == '0));

  // R3: flags are mutually exclusive
  a_r3_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones({out_invalid, out_overflow, out_inexact}) <= 1));

endmodule

// File: tb/dtoi_conv_bench.sv
module dtoi_conv_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_data = '0;
  logic [1:0]  in_mode = '0;
  logic        in_report = 1'b0;
  logic        out_valid;
  logic [63:0] out_result;
  logic        out_invalid, out_overflow, out_inexact;

  always #5 clk = ~clk;

  dtoi_conv u_dtoi_conv (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_mode(in_mode), .in_report(in_report), .out_valid(out_valid),
    .out_result(out_result), .out_invalid(out_invalid),
    .out_overflow(out_overflow), .out_inexact(out_inexact)
  );

  typedef struct {
    logic [63:0] res;
    logic        inv, ovf, inx;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   total = 0;
  int   bad = 0;
  bit   finished = 0;

  // Independent reference: integer/remainder split by mask, not by alignment.
  function automatic void model(input logic [63:0] a, input logic [1:0] md,
                                input logic rp, output exp_t e);
    logic        s;
    logic [10:0] ex;
    logic [51:0] fr;
    logic [63:0] ip, low, half, m;
    logic        gt, eq, nz, inc;
    int          p, k;
    s = a[63]; ex = a[62:52]; fr = a[51:0];
    e.inv = 0; e.ovf = 0; e.inx = 0; e.res = '0;
    ip = '0; gt = 0; eq = 0; nz = 0;
    if (ex == 11'h7FF) begin
      e.inv = (fr != 0);
      e.ovf = (fr == 0) && rp;
      return;
    end
    if (ex == 0 && fr == 0) return;
    if (ex == 0) begin
      nz = 1;
    end else begin
      m = {11'b0, 1'b1, fr};
      p = int'(ex) - 1075;
      if (p >= 0) begin
        if (p < 63) begin
          ip = m << p;
          e.ovf = rp && (p >= 12);
        end
      end else begin
        k = -p;
        if (k <= 62) begin
          ip   = m >> k;
          low  = m & ((64'd1 << k) - 64'd1);
          half = 64'd1 << (k - 1);
          gt   = low > half;
          eq   = low == half;
          nz   = low != 0;
        end else begin
          nz = 1;
        end
      end
    end
    case (md)
      2'b00: inc = gt || (eq && ip[0]);
      2'b01: inc = 0;
      2'b10: inc = s && nz;
      default: inc = !s && nz;
    endcase
    ip = ip + {63'b0, inc};
    e.res = s ? (64'd0 - ip) : ip;
    e.inx = rp && nz;
  endfunction

  task automatic send(input logic [63:0] a, input logic [1:0] md,
                      input logic rp, input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; in_data = a; in_mode = md; in_report = rp;
    model(a, md, rp, e);
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Monitor: compare each produced result with the queued expectation.
  always @(negedge clk) begin
    if (rst_n && out_valid && !finished) begin
      total++;
      if (q.size() == 0) begin
        bad++;
        $display("FAIL R1 unexpected out_valid: got 1 expected 0");
      end else begin
        exp_t e;
        e = q.pop_front();
        if (out_result !== e.res || out_invalid !== e.inv ||
            out_overflow !== e.ovf || out_inexact !== e.inx) begin
          bad++;
          $display("FAIL %s: got res=%h inv=%b ovf=%b inx=%b expected res=%h inv=%b ovf=%b inx=%b",
                   e.tag, out_result, out_invalid, out_overflow, out_inexact,
                   e.res, e.inv, e.ovf, e.inx);
        end
      end
    end
  end

  task automatic check_idle(input string tag);
    @(negedge clk);
    total++;
    if (out_valid !== 1'b0) begin
      bad++;
      $display("FAIL %s: got out_valid=%b expected 0", tag, out_valid);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (out_valid !== 0 || out_result !== 0 || out_invalid !== 0 ||
        out_overflow !== 0 || out_inexact !== 0) begin
      bad++;
      $display("FAIL R1 reset state: got v=%b res=%h expected v=0 res=0", out_valid, out_result);
    end
    rst_n = 1'b1;
    check_idle("R1 idle after reset");

    send(64'h3FF0000000000000, 2'b00, 1, "R2 one");
    send(64'hC014000000000000, 2'b00, 1, "R2 R12 minus five");
    send(64'h0000000000000000, 2'b11, 1, "R2 plus zero");
    send(64'h8000000000000000, 2'b10, 1, "R2 minus zero");
    send(64'h43E0000000000000, 2'b00, 1, "R3 two pow 63 fits");
    send(64'h43F0000000000000, 2'b00, 1, "R3 two pow 64 overflow");
    send(64'h43F8000000000000, 2'b00, 1, "R3 wrap low bits");
    send(64'h7E70000000000000, 2'b00, 1, "R3 huge shift gives zero");
    send(64'h4004000000000000, 2'b00, 1, "R4 2.5 to even");
    send(64'h400C000000000000, 2'b00, 1, "R4 3.5 to even");
    send(64'h4006000000000000, 2'b00, 1, "R4 2.75 above half");
    send(64'h3FE0000000000000, 2'b00, 1, "R4 0.5 to zero");
    send(64'hC004000000000000, 2'b00, 1, "R4 R12 minus 2.5");
    send(64'h4004000000000000, 2'b01, 1, "R5 2.5 truncate");
    send(64'hC006000000000000, 2'b01, 1, "R5 R12 minus 2.75 truncate");
    send(64'h4004000000000000, 2'b10, 1, "R6 plus 2.5 down");
    send(64'hC004000000000000, 2'b10, 1, "R6 minus 2.5 down");
    send(64'h4004000000000000, 2'b11, 1, "R7 plus 2.5 up");
    send(64'hC004000000000000, 2'b11, 1, "R7 minus 2.5 up");
    send(64'h0100000000000000, 2'b11, 1, "R8 tiny up");
    send(64'h8100000000000000, 2'b10, 1, "R8 tiny negative down");
    send(64'h0100000000000000, 2'b00, 1, "R8 tiny nearest");
    send(64'h0000000000000001, 2'b11, 1, "R9 denormal up");
    send(64'h8000000000000001, 2'b10, 1, "R9 denormal negative down");
    send(64'h000FFFFFFFFFFFFF, 2'b00, 1, "R9 denormal nearest");
    send(64'h7FF8000000000000, 2'b00, 0, "R10 NaN report off");
    send(64'hFFF0000000000001, 2'b00, 1, "R10 negative NaN");
    send(64'h7FF0000000000000, 2'b00, 1, "R10 infinity report on");
    send(64'hFFF0000000000000, 2'b00, 0, "R10 R11 infinity report off");
    send(64'h43F8000000000000, 2'b00, 0, "R11 wrap report off");
    send(64'h4006000000000000, 2'b00, 0, "R11 inexact report off");
    idle(1);
    check_idle("R1 no strobe");

    for (int i = 0; i < 400; i++) begin
      logic [63:0] v;
      v = {$urandom, $urandom};
      v[62:52] = 11'(990 + ($urandom % 110));
      send(v, 2'($urandom), 1'($urandom), "R4 R5 R6 R7 R12 random");
      if (i % 37 == 0) idle(1);
    end
    idle(3);
    total++;
    if (q.size() != 0) begin
      bad++;
      $display("FAIL R1 results missing: got %0d pending expected 0", q.size());
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL R1 watchdog: got hang expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule